// File: doc/BRIEF.md
# Transmit Frame Padder and CRC-32 Appender

This block sits in the transmit path of an Ethernet MAC. It takes a frame, held as a stream of wide words from a transmit FIFO, and turns it into a byte stream. The frame runs from the destination address to the last payload byte. Inside each word the lowest byte lane is sent first. A count on the final word says how many of its lanes hold frame bytes.

Two enables are applied per frame. With padding on, a frame whose body is short gets zero bytes added until the payload reaches the minimum length. The body is the 14 header bytes plus the payload. With CRC generation on, the block computes the IEEE 802.3 CRC-32 over every byte it sent for the frame, pad bytes included, and sends it as four extra bytes. With CRC generation off, no check bytes are added. Software can then put its own check bytes at the end of the frame, for example to produce a deliberately corrupted frame.

The input side and the output byte side both use valid/ready handshakes. The block holds no data buffer. A word stays on the input until its last lane has been taken by the output.

Top module: `txpf_top`

## Requirements
- R1: Each input word is sent as bytes, bits 7:0 first, then 15:8, 23:16 and 31:24. Header bytes, including the two-byte length/type field, leave in the order the FIFO supplies them.
- R2: On a word with `in_last` high, `in_bytes` gives the number of valid lanes, with 0 meaning all four. Only the lanes from 0 up to that count are sent, and the other lanes are never output.
- R3: When `in_pad_en` is 1 and the frame body is shorter than 60 bytes (a payload of under 46 bytes after the 14-byte header), bytes of value 0x00 follow the last input byte until the body is 60 bytes long.
- R4: No pad byte is added when `in_pad_en` is 0, or when the body is already 60 bytes or longer.
- R5: When `in_crc_en` is 1, four bytes follow the body (pad included). They are the bitwise complement of the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones), least significant byte first. For the ASCII string "123456789" this CRC is 0xCBF43926.
- R6: When `in_crc_en` is 0, the frame ends with the last input byte or the last pad byte, and nothing follows it.
- R7: Both enables are taken from the final input word of the frame only. Their values on earlier words of the frame have no effect.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values and `out_valid` stays high. `in_ready` is high only in a cycle where the last lane of the word is being accepted at the output.
- R9: After reset, with no input offered, `out_valid` and `in_ready` are low.
- R10: `out_last` is high on exactly the final byte of each frame, whichever of body, pad or CRC byte that is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word consumed this cycle |
| in_data | input | DATA_W (32) | Frame word, lane 0 first |
| in_last | input | 1 | Final word of the frame |
| in_bytes | input | log2(DATA_W/8) (2) | Valid lanes on the final word, 0 = all |
| in_pad_en | input | 1 | Pad short frames (read on final word) |
| in_crc_en | input | 1 | Append CRC-32 (read on final word) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The bench builds the block with its default parameters: 32-bit words (four lanes), a 14-byte header and a 46-byte minimum payload. With four lanes, every final-word count from one to four occurs among the chosen frame lengths. The lengths are placed on both sides of the 60-byte body threshold (59, 60, 61, 62) and far below it (1, 14, 23, 45), so the pad and no-pad decisions are both exercised at the boundary. Frames with random output backpressure show the stall behaviour inside the body, pad and CRC phases.

// File: rtl/txpf_pkg.sv
package txpf_pkg;

   typedef enum logic [1:0] {
      ST_BODY = 2'd0,
      ST_PAD  = 2'd1,
      ST_FCS  = 2'd2
   } txpf_state_e;

   // bit-reverse a 32-bit word (normal polynomial -> reflected form)
   function automatic logic [31:0] reflect32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
      return r;
   endfunction

   // one byte through a reflected CRC-32 register, LSB first
   function automatic logic [31:0] crc32_step(input logic [31:0] c,
                                              input logic [7:0]  d,
                                              input logic [31:0] rpoly);
      logic [31:0] x;
      x = c ^ {24'd0, d};
      for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ rpoly) : (x >> 1);
      return x;
   endfunction

endpackage

// File: rtl/txpf_lane_sel.sv
module txpf_lane_sel #(
   parameter int DATA_W = 32,
   localparam int LANES  = DATA_W / 8,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] word,
   input  logic [LANE_W-1:0] lane,
   output logic [7:0]        byte_o
);

   logic [7:0] lanes_a [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes_a[g] = word[8*g +: 8];
   end

   assign byte_o = lanes_a[lane];

endmodule

// File: rtl/txpf_crc32.sv
module txpf_crc32 import txpf_pkg::*; #(
   parameter logic [31:0] POLY = 32'h04C11DB7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        upd,
   input  logic [7:0]  din,
   output logic [31:0] crc
);

   localparam logic [31:0] RPOLY = reflect32(POLY);

   always_ff @(posedge clk) begin
      if (!rst_n || init) crc <= '1;
      else if (upd)       crc <= crc32_step(crc, din, RPOLY);
   end

endmodule

// File: rtl/txpf_top.sv
module txpf_top import txpf_pkg::*; #(
   parameter int          DATA_W      = 32,
   parameter int          HDR_BYTES   = 14,
   parameter int          MIN_PAYLOAD = 46,
   parameter logic [31:0] CRC_POLY    = 32'h04C11DB7,
   localparam int LANES  = DATA_W / 8,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   input  logic [LANE_W-1:0] in_bytes,
   input  logic              in_pad_en,
   input  logic              in_crc_en,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_last
);

   localparam int MIN_BODY = HDR_BYTES + MIN_PAYLOAD;
   localparam int CNT_W    = $clog2(MIN_BODY + 1);
   localparam logic [CNT_W-1:0] BODY_END = CNT_W'(MIN_BODY);

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("txpf_top: DATA_W must be a multiple of 8 and at least 16");
   end
   if ((LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("txpf_top: DATA_W/8 must be a power of two");
   end
   if (MIN_BODY < 1) begin : g_bad_min
      $error("txpf_top: minimum body length must be positive");
   end

   txpf_state_e       st;
   logic [LANE_W-1:0] lane;
   logic [LANE_W-1:0] last_lane;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_inc;
   logic [1:0]        fcs_idx;
   logic              crc_q;
   logic [7:0]        lane_byte;
   logic [31:0]       crc_val;
   logic              word_end;
   logic              frame_end;
   logic              pad_req;
   logic              fire;
   logic              crc_init;
   logic              crc_upd;

   txpf_lane_sel #(.DATA_W(DATA_W)) u_lane (
      .word   (in_data),
      .lane   (lane),
      .byte_o (lane_byte)
   );

   txpf_crc32 #(.POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (crc_init),
      .upd   (crc_upd),
      .din   (out_data),
      .crc   (crc_val)
   );

   // lane count of 0 wraps to the top lane: a full final word
   assign last_lane = in_last ? (in_bytes - 1'b1) : LANE_W'(LANES - 1);
   assign word_end  = (lane == last_lane);
   assign frame_end = in_last && word_end;
   assign cnt_inc   = (cnt == BODY_END) ? cnt : cnt + 1'b1;
   assign pad_req   = in_pad_en && (cnt_inc < BODY_END);
   assign fire      = out_valid && out_ready;

   always_comb begin
      out_valid = 1'b0;
      out_data  = 8'd0;
      out_last  = 1'b0;
      in_ready  = 1'b0;
      crc_init  = 1'b0;
      crc_upd   = 1'b0;
      unique case (st)
         ST_BODY: begin
            out_valid = in_valid;
            out_data  = lane_byte;
            out_last  = frame_end && !pad_req && !in_crc_en;
            in_ready  = in_valid && out_ready && word_end;
            crc_upd   = fire;
            crc_init  = fire && out_last;
         end
         ST_PAD: begin
            out_valid = 1'b1;
            out_last  = (cnt_inc == BODY_END) && !crc_q;
            crc_upd   = fire;
            crc_init  = fire && out_last;
         end
         ST_FCS: begin
            out_valid = 1'b1;
            out_data  = ~crc_val[8*fcs_idx +: 8];
            out_last  = (fcs_idx == 2'd3);
            crc_init  = fire && out_last;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_BODY;
         lane    <= '0;
         cnt     <= '0;
         fcs_idx <= '0;
         crc_q   <= 1'b0;
      end else if (fire) begin
         unique case (st)
            ST_BODY: begin
               lane <= word_end ? '0 : lane + 1'b1;
               cnt  <= cnt_inc;
               if (frame_end) begin
                  crc_q <= in_crc_en;
                  if (pad_req)        st  <= ST_PAD;
                  else if (in_crc_en) st  <= ST_FCS;
                  else                cnt <= '0;
               end
            end
            ST_PAD: begin
               cnt <= cnt_inc;
               if (cnt_inc == BODY_END) begin
                  if (crc_q) st <= ST_FCS;
                  else begin
                     st  <= ST_BODY;
                     cnt <= '0;
                  end
               end
            end
            ST_FCS: begin
               fcs_idx <= fcs_idx + 1'b1;
               if (fcs_idx == 2'd3) begin
                  st  <= ST_BODY;
                  cnt <= '0;
               end
            end
            default: st <= ST_BODY;
         endcase
      end
   end

endmodule

// File: rtl/txpf_chk.sv
module txpf_chk #(
   parameter int MIN_BODY = 60
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic       in_last,
   input logic       in_pad_en,
   input logic       in_crc_en,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic       out_last
);

   localparam int CW = $clog2(MIN_BODY + 8);
   localparam logic [CW-1:0] SAT = CW'(MIN_BODY + 4);

   logic          out_fire;
   logic          in_end;
   logic          pad_seen;
   logic          crc_seen;
   logic          pad_flag;
   logic          crc_flag;
   logic [CW-1:0] fcnt;

   assign out_fire = out_valid && out_ready;
   assign in_end   = in_valid && in_ready && in_last;
   assign pad_flag = in_end ? in_pad_en : pad_seen;
   assign crc_flag = in_end ? in_crc_en : crc_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fcnt     <= '0;
         pad_seen <= 1'b0;
         crc_seen <= 1'b0;
      end else begin
         if (in_end) begin
            pad_seen <= in_pad_en;
            crc_seen <= in_crc_en;
         end
         if (out_fire) fcnt <= out_last ? '0 : ((fcnt == SAT) ? fcnt : fcnt + 1'b1);
      end
   end

   // R8: a stalled byte is held unchanged
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   // R8: a word leaves the input only together with an accepted byte
   assert_word_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> out_valid && out_ready);

   // R3: padded frames reach the minimum body (plus CRC when enabled)
   assert_min_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire && out_last && pad_flag |->
         (int'(fcnt) + 1 >= MIN_BODY + (crc_flag ? 4 : 0)));

   // R6: with neither enable the frame ends on its final input byte
   assert_no_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire && out_last && !pad_flag && !crc_flag |-> in_valid && in_ready && in_last);

endmodule

bind txpf_top txpf_chk #(.MIN_BODY(HDR_BYTES + MIN_PAYLOAD)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .in_pad_en (in_pad_en),
   .in_crc_en (in_crc_en),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_last  (out_last)
);

// File: tb/txpf_top_tb.sv
module txpf_top_tb;

   localparam int DW = 32;
   localparam int LN = DW / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_data = '0;
   logic          in_last = 1'b0;
   logic [1:0]    in_bytes = '0;
   logic          in_pad_en = 1'b0;
   logic          in_crc_en = 1'b0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [7:0]    out_data;
   logic          out_last;

   always #10 clk = ~clk;

   txpf_top u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_last   (in_last),
      .in_bytes  (in_bytes),
      .in_pad_en (in_pad_en),
      .in_crc_en (in_crc_en),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [7:0] exp_d[$];
   bit         exp_l[$];
   string      exp_dt[$];
   string      exp_lt[$];

   bit          bp = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   bit         prev_stall = 1'b0;
   logic [7:0] prev_d = '0;
   logic       prev_l = 1'b0;

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
      logic [31:0] c = 32'hFFFF_FFFF;
      foreach (b[i]) begin
         c = c ^ {24'd0, b[i]};
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      return ~c;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // output ready pattern
   always @(posedge clk) begin
      lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= bp ? (lfsr[0] | lfsr[3]) : 1'b1;
   end

   // reference comparison on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (prev_stall)
            check(out_valid && out_data == prev_d && out_last == prev_l, "R8",
                  {23'd0, out_valid, out_last, out_data}, {23'd0, 1'b1, prev_l, prev_d});
         if (out_valid && out_ready) begin
            if (exp_d.size() == 0) begin
               check(1'b0, "R6", {24'd0, out_data}, 32'd0);
            end else begin
               logic [7:0] ed;
               bit         el;
               string      dt;
               string      lt;
               ed = exp_d.pop_front();
               el = exp_l.pop_front();
               dt = exp_dt.pop_front();
               lt = exp_lt.pop_front();
               check(out_data == ed, dt, {24'd0, out_data}, {24'd0, ed});
               check(out_last == el, lt, {31'd0, out_last}, {31'd0, el});
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_d     = out_data;
         prev_l     = out_last;
      end
   end

   // len: body bytes supplied; pad/crc: enables on the final word
   task automatic send_frame(input int len, input bit pad, input bit crc,
                             input int seed, input string ltag);
      logic [7:0]  fb[$];
      logic [7:0]  body[$];
      logic [31:0] f;
      int          nw;
      int          full;
      for (int i = 0; i < len; i++) fb.push_back(8'((i * 7 + seed * 13 + 3) & 8'hFF));
      body = fb;
      if (pad) while (body.size() < 60) body.push_back(8'h00);
      if (crc) begin
         f = ref_crc(body);
         for (int k = 0; k < 4; k++) body.push_back(f[8*k +: 8]);
      end
      full = (len / LN) * LN;
      foreach (body[i]) begin
         exp_d.push_back(body[i]);
         exp_l.push_back(i == body.size() - 1);
         if (i < full)     exp_dt.push_back("R1");
         else if (i < len) exp_dt.push_back("R2");
         else if (crc && i >= body.size() - 4) exp_dt.push_back("R5");
         else              exp_dt.push_back("R3");
         exp_lt.push_back(i == body.size() - 1 ? ltag : "R10");
      end
      nw = (len + LN - 1) / LN;
      for (int w = 0; w < nw; w++) begin
         logic [DW-1:0] wd;
         for (int k = 0; k < LN; k++) begin
            int idx = w * LN + k;
            wd[8*k +: 8] = (idx < len) ? fb[idx] : 8'hEE;
         end
         in_data   = wd;
         in_last   = (w == nw - 1);
         in_bytes  = (w == nw - 1) ? 2'(len % LN) : 2'd0;
         // R7: opposite enables on non-final words must not matter
         in_pad_en = (w == nw - 1) ? pad : ~pad;
         in_crc_en = (w == nw - 1) ? crc : ~crc;
         in_valid  = 1'b1;
         @(negedge clk);
         while (!in_ready) @(negedge clk);
         @(posedge clk);
         #1;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic drain();
      int guard = 0;
      while (exp_d.size() != 0 && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] vec[$];
      // R5: reference CRC against the standard check string
      vec = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      check(ref_crc(vec) == 32'hCBF4_3926, "R5", ref_crc(vec), 32'hCBF4_3926);

      repeat (4) @(posedge clk);
      @(negedge clk);
      check(!out_valid && !in_ready, "R9", {30'd0, out_valid, in_ready}, 32'd0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!out_valid && !in_ready, "R9", {30'd0, out_valid, in_ready}, 32'd0);
      @(posedge clk);
      #1;

      send_frame(14, 1'b1, 1'b1, 1, "R3");   // header only, padded and CRC
      send_frame(60, 1'b1, 1'b1, 2, "R4");   // exactly minimum, no pad
      send_frame(59, 1'b1, 1'b0, 3, "R6");   // one pad byte, no CRC
      send_frame(45, 1'b0, 1'b1, 4, "R4");   // short, padding off
      send_frame(64, 1'b0, 1'b0, 5, "R6");   // software-supplied check bytes
      drain();
      bp = 1'b1;
      send_frame(61, 1'b1, 1'b1, 6, "R5");
      send_frame(23, 1'b1, 1'b1, 7, "R3");
      send_frame(62, 1'b0, 1'b1, 8, "R5");
      send_frame(1,  1'b0, 1'b0, 9, "R2");
      send_frame(33, 1'b1, 1'b0, 10, "R7");
      drain();
      bp = 1'b0;
      repeat (6) @(posedge clk);
      @(negedge clk);
      // R6: nothing further appears once all frames are done
      check(exp_d.size() == 0 && !out_valid, "R6",
            {31'd0, out_valid} | 32'(exp_d.size()), 32'd0);
      finish_run();
   end

endmodule